// File: doc/BRIEF.md
# Cache Block Refill Memory Sequencer

This block stands in for the main-memory side of a cache refill. A cache controller asks for one block, four words of 32 bits. The block then plays out the bus cycles that a real memory would spend. These are one cycle to carry the address, the DRAM access time, and one cycle per data transfer. It returns the words on a block-wide data port with one valid strobe per word lane. The `ORG` parameter, fixed when the block is built, selects one of three memory layouts:

- **Narrow:** a one-word DRAM that fetches and transfers the words one at a time.
- **Wide:** a four-word DRAM that fetches and transfers the whole block at once.
- **Interleaved:** four one-word banks that fetch in parallel and then transfer in turn.

The content of the memory is a small register array. Reset fills it with a fixed pattern. After each refill, the block reports the measured refill latency in bus cycles, so the three layouts can be compared directly.

Cycle numbering used below: cycle 1 is the first bus cycle after the clock edge at which a request is accepted.

Top module: `refill_seq`

## Requirements
- R1: A request is accepted at a clock edge where `req_valid_i` and `ready_o` are both high, and the block index is captured at that edge. `ready_o` is low from cycle 1 through the cycle of the final transfer. It is high in every other cycle.
- R2: Requests and block indices presented while `ready_o` is low have no effect. The words returned always belong to the block captured at acceptance.
- R3: With ORG=0 (narrow), word w appears alone on lane w in cycle 17+16·w. The refill therefore ends in cycle 65.
- R4: With ORG=1 (wide), all four lanes are valid together in cycle 17, and nowhere else.
- R5: With ORG=2 (interleaved), word w appears alone on lane w in cycle 17+w. The refill therefore ends in cycle 20.
- R6: `done_o` is high for exactly one cycle, the cycle of the final transfer, and lane 3 is valid in that cycle.
- R7: After the edge that ends the `done_o` cycle, `last_latency_o` equals the total refill length: 65, 17 or 20 for ORG 0, 1 or 2. It holds that value until the next refill completes.
- R8: Lane w occupies bits [32w+31:32w] of `lane_data_o`. When lane w is valid, it carries 32'hC0DE0000 + 4·b + w, where b is the captured block index. Lanes that are not valid drive zero.
- R9: While reset is asserted, `ready_o` is high, `lane_valid_o` and `done_o` are low, and `last_latency_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Block-read request |
| req_block_i | input | 4 | Index of the requested block |
| ready_o | output | 1 | Idle; a request is accepted at the next edge |
| lane_valid_o | output | 4 | Per-word strobe, bit w for word w |
| lane_data_o | output | 128 | Word w in bits [32w+31:32w] |
| done_o | output | 1 | Final transfer of the refill |
| last_latency_o | output | 8 | Bus cycles taken by the last completed refill |

## Verification
The bench builds three copies side by side, one per layout (ORG = 0, 1 and 2). It drives each copy with the same request pattern, so one run covers:
- the serial access-then-transfer chain of the narrow layout;
- the single wide transfer;
- the back-to-back transfers after a shared access in the interleaved layout.

The reference model checks every cycle in all three copies: word ordering, strobe placement, done timing and the 65/17/20 latency figures. Requests are held high with changing indices during busy periods, to show they are ignored. The block list includes the lowest and highest indices.

// File: rtl/refill_pkg.sv
package refill_pkg;
  localparam int ORG_NARROW      = 0;
  localparam int ORG_WIDE        = 1;
  localparam int ORG_INTERLEAVED = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_ACCESS = 2'd2,
    PH_XFER   = 2'd3
  } phase_e;
endpackage

// File: rtl/refill_store.sv
module refill_store #(
  parameter int               WORD_W     = 32,
  parameter int               WORDS      = 4,
  parameter int               MEM_BLOCKS = 16,
  parameter logic [WORD_W-1:0] DATA_BASE = 32'hC0DE_0000,
  localparam int              BLK_W      = $clog2(MEM_BLOCKS),
  localparam int              ENTRIES    = MEM_BLOCKS * WORDS,
  localparam int              IDX_W      = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BLK_W-1:0]        rd_block_i,
  output logic [WORDS*WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [ENTRIES];

  // Content is loaded by reset only; there is no write path.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        mem_q[i] <= DATA_BASE + WORD_W'(i);
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    logic [IDX_W-1:0] idx;
    assign idx = IDX_W'(rd_block_i) * IDX_W'(WORDS) + IDX_W'(w);
    assign rd_data_o[w*WORD_W +: WORD_W] = mem_q[idx];
  end
endmodule

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int  ACCESS_CYC = 15,
  localparam int CNT_W      = $clog2(ACCESS_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    cnt_n  = start_i ? CNT_W'(ACCESS_CYC) : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CNT_W'(1));

  // A bank must not be restarted in the middle of its access (R3, R5).
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_o) |-> !start_i);
endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int               ORG        = ORG_NARROW,
  parameter int               WORD_W     = 32,
  parameter int               WORDS      = 4,
  parameter int               MEM_BLOCKS = 16,
  parameter int               ADDR_CYC   = 1,
  parameter int               ACCESS_CYC = 15,
  parameter int               LAT_W      = 8,
  parameter logic [WORD_W-1:0] DATA_BASE = 32'hC0DE_0000,
  localparam int              BLK_W      = $clog2(MEM_BLOCKS),
  localparam int              PTR_W      = $clog2(WORDS),
  localparam int              NBANK      = (ORG == ORG_INTERLEAVED) ? WORDS : 1,
  localparam int              ACNT_W     = $clog2(ADDR_CYC + 1),
  localparam int              TOTAL      = (ORG == ORG_NARROW) ? ADDR_CYC + WORDS * (ACCESS_CYC + 1) :
                                           (ORG == ORG_WIDE)   ? ADDR_CYC + ACCESS_CYC + 1 :
                                                                 ADDR_CYC + ACCESS_CYC + WORDS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid_i,
  input  logic [BLK_W-1:0]        req_block_i,
  output logic                    ready_o,
  output logic [WORDS-1:0]        lane_valid_o,
  output logic [WORDS*WORD_W-1:0] lane_data_o,
  output logic                    done_o,
  output logic [LAT_W-1:0]        last_latency_o
);
  phase_e             phase_q, phase_n;
  logic [BLK_W-1:0]   blk_q, blk_n;
  logic [PTR_W-1:0]   ptr_q, ptr_n;
  logic [ACNT_W-1:0]  acnt_q, acnt_n;
  logic [LAT_W-1:0]   lat_q, lat_n;
  logic [LAT_W-1:0]   last_lat_q;
  logic               accept, timer_start, all_last, final_xfer;
  logic [NBANK-1:0]   bank_last;
  logic [NBANK-1:0]   bank_busy;
  logic [WORDS*WORD_W-1:0] store_data;

  // One access timer per bank; a single shared one when there is one bank.
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_timer #(.ACCESS_CYC(ACCESS_CYC)) i_bank_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(timer_start),
      .busy_o (bank_busy[b]),
      .last_o (bank_last[b])
    );
  end

  refill_store #(
    .WORD_W(WORD_W), .WORDS(WORDS), .MEM_BLOCKS(MEM_BLOCKS), .DATA_BASE(DATA_BASE)
  ) i_refill_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_block_i(blk_q),
    .rd_data_o (store_data)
  );

  assign all_last   = &bank_last;
  assign accept     = (phase_q == PH_IDLE) && req_valid_i;
  assign final_xfer = (phase_q == PH_XFER) &&
                      ((ORG == ORG_WIDE) || (ptr_q == PTR_W'(WORDS - 1)));

  always_comb begin
    phase_n     = phase_q;
    blk_n       = blk_q;
    ptr_n       = ptr_q;
    acnt_n      = acnt_q;
    lat_n       = lat_q + LAT_W'(1);
    timer_start = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        lat_n = lat_q;
        if (accept) begin
          phase_n = PH_ADDR;
          blk_n   = req_block_i;
          ptr_n   = '0;
          acnt_n  = ACNT_W'(ADDR_CYC);
          lat_n   = LAT_W'(1);
        end
      end
      PH_ADDR: begin
        acnt_n = acnt_q - ACNT_W'(1);
        if (acnt_q == ACNT_W'(1)) begin
          phase_n     = PH_ACCESS;
          timer_start = 1'b1;
        end
      end
      PH_ACCESS: begin
        if (all_last) phase_n = PH_XFER;
      end
      PH_XFER: begin
        if (final_xfer) begin
          phase_n = PH_IDLE;
        end else begin
          ptr_n = ptr_q + PTR_W'(1);
          if (ORG == ORG_NARROW) begin
            phase_n     = PH_ACCESS;
            timer_start = 1'b1;
          end
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      blk_q      <= '0;
      ptr_q      <= '0;
      acnt_q     <= '0;
      lat_q      <= '0;
      last_lat_q <= '0;
    end else begin
      phase_q <= phase_n;
      lat_q   <= lat_n;
      acnt_q  <= acnt_n;
      ptr_q   <= ptr_n;
      if (accept)     blk_q      <= blk_n;
      if (final_xfer) last_lat_q <= lat_q;
    end
  end

  always_comb begin
    lane_valid_o = '0;
    if (phase_q == PH_XFER) begin
      if (ORG == ORG_WIDE) lane_valid_o = '1;
      else                 lane_valid_o[ptr_q] = 1'b1;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_out
    assign lane_data_o[w*WORD_W +: WORD_W] =
      lane_valid_o[w] ? store_data[w*WORD_W +: WORD_W] : '0;
  end

  assign ready_o        = (phase_q == PH_IDLE);
  assign done_o         = final_xfer;
  assign last_latency_o = last_lat_q;

  // R1: acceptance makes the block busy at once.
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && ready_o) |=> !ready_o);
  // R1: the block is idle again right after the final transfer.
  assert_ready_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> ready_o);
  // R2: the captured block index cannot move while busy.
  assert_block_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |=> $stable(blk_q));
  // R6: done only accompanies the last word, and only for one cycle.
  assert_done_last_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> lane_valid_o[WORDS-1]);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: the measured latency equals the organisation's closed-form total.
  assert_latency_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (last_latency_o == LAT_W'(TOTAL)));
  // R8: no strobe while idle.
  assert_no_lane_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (lane_valid_o == '0));
  if (ORG != ORG_WIDE) begin : g_serial_chk
    // R3, R5: word-serial layouts deliver one lane at a time.
    assert_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_valid_o));
  end
endmodule

// File: tb/test_refill_seq.sv
module test_refill_seq;
  localparam int WORDS = 4;
  localparam int WW    = 32;
  localparam int NREQ  = 6;
  localparam logic [31:0] BASE = 32'hC0DE_0000;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic         req_valid [3];
  logic [3:0]   req_block [3];
  logic         ready     [3];
  logic [3:0]   lanes     [3];
  logic [127:0] data      [3];
  logic         done      [3];
  logic [7:0]   lat       [3];

  for (genvar g = 0; g < 3; g++) begin : g_org
    refill_seq #(.ORG(g)) i_refill_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid_i   (req_valid[g]),
      .req_block_i   (req_block[g]),
      .ready_o       (ready[g]),
      .lane_valid_o  (lanes[g]),
      .lane_data_o   (data[g]),
      .done_o        (done[g]),
      .last_latency_o(lat[g])
    );
  end

  int n_checks = 0;
  int n_bad    = 0;
  int k[3], mblk[3], mlat[3], issued[3];
  int cyc = 0;

  function automatic int total(int o);
    return (o == 0) ? 65 : (o == 1) ? 17 : 20;
  endfunction

  function automatic int slot(int o, int w);
    return (o == 0) ? 17 + 16 * w : (o == 1) ? 17 : 17 + w;
  endfunction

  function automatic logic [3:0] blk_list(int i);
    return 4'((i * 11 + 15) % 16);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  // Reference model, advanced at each rising edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int o = 0; o < 3; o++) begin
      if (!rst_n) begin
        k[o] = 0; mlat[o] = 0;
      end else if (k[o] == 0) begin
        if (req_valid[o]) begin
          k[o] = 1; mblk[o] = int'(req_block[o]); issued[o]++;
        end
      end else if (k[o] == total(o)) begin
        mlat[o] = total(o); k[o] = 0;
      end else begin
        k[o]++;
      end
    end
  end

  // Compare on the falling edge, then drive the next inputs.
  always @(negedge clk) begin
    for (int o = 0; o < 3; o++) begin
      logic [3:0]   exp_l;
      logic [127:0] exp_d;
      string        ltag;
      exp_l = '0;
      exp_d = '0;
      for (int w = 0; w < WORDS; w++) begin
        if (rst_n && k[o] != 0 && k[o] == slot(o, w)) begin
          exp_l[w] = 1'b1;
          exp_d[w*WW +: WW] = BASE + 32'(mblk[o] * 4 + w);
        end
      end
      ltag = (o == 0) ? "R3" : (o == 1) ? "R4" : "R5";
      if (!rst_n) begin
        chk(ready[o] === 1'b1 && lanes[o] === 4'b0 && done[o] === 1'b0 && lat[o] === 8'd0,
            "R9", "reset state", {ready[o], lanes[o], done[o], lat[o]}, {1'b1, 4'b0, 1'b0, 8'd0});
      end else begin
        chk(ready[o] === (k[o] == 0), "R1", "ready", 128'(ready[o]), 128'(k[o] == 0));
        chk(lanes[o] === exp_l, ltag, "lane strobes", 128'(lanes[o]), 128'(exp_l));
        chk(data[o] === exp_d, "R8/R2", "lane data", data[o], exp_d);
        chk(done[o] === (k[o] == total(o)), "R6", "done", 128'(done[o]), 128'(k[o] == total(o)));
        chk(lat[o] === 8'(mlat[o]), "R7", "latency", 128'(lat[o]), 128'(mlat[o]));
      end
      // Busy periods keep requesting with shifting indices (R2).
      req_valid[o] = rst_n && (issued[o] < NREQ) && (cyc % 3 != 1);
      req_block[o] = (k[o] == 0) ? blk_list(issued[o]) : 4'(cyc * 5 + o);
    end
  end

  initial begin
    for (int o = 0; o < 3; o++) begin
      req_valid[o] = 1'b0; req_block[o] = '0; issued[o] = 0; k[o] = 0; mlat[o] = 0; mblk[o] = 0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    wait (issued[0] == NREQ && issued[1] == NREQ && issued[2] == NREQ &&
          k[0] == 0 && k[1] == 0 && k[2] == 0);
    repeat (3) @(negedge clk);
    #1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule